// File: doc/BRIEF.md
# Ethernet frame-start synchroniser

This block sits on one receive port and finds where a frame's payload begins. It works in one of two line modes, chosen by a static mode input. In serial mode it takes one bit per clock, qualified by a carrier-sense input. In MII mode it takes one 4-bit nibble per clock, qualified by a receive-data-valid input. The detector starts hunting when its qualifier goes high. It checks the preamble and then looks for the start-of-frame delimiter.

When the delimiter is found, the block pulses a frame-start flag. It then passes the line data through with a valid strobe to the byte assembler downstream. If the preamble is malformed, it pulses an abort flag and ignores the line for the rest of that qualifier period. A qualifier that drops before any delimiter sends the detector quietly back to idle.

Top module: `eth_sfd_detect`

## Requirements
- R1: While rst_ni is low, sof_o, abort_o and dat_vld_o are low, whatever the line inputs do.
- R2: In serial mode (mii_mode_i=0), the bits 1,0,1,0,1,0 followed by 1,1 on ser_d_i, oldest first and all with crs_i high, raise sof_o for exactly the cycle after the last 1.
- R3: In serial mode, a "11" pair preceded by fewer than six alternating bits (for example 1,0,1,0,1,1 right after carrier rises) does not raise sof_o.
- R4: In serial mode, the first bit after crs_i rises has index 0. Two consecutive 0 bits whose second bit has index 16 or more, seen before a delimiter, raise abort_o on the following cycle. A 00 pair whose second bit has index 15 or less causes no abort.
- R5: In MII mode (mii_mode_i=1), nibble 4'h5 followed by nibble 4'hD on rxd_i (bit 3 down to bit 0) with rx_dv_i high raises sof_o for the cycle after the 4'hD nibble.
- R6: In MII mode, before a delimiter, a nibble that is neither 4'h5 nor a 4'hD directly after 4'h5 raises abort_o on the following cycle. This includes 4'hD as the first nibble.
- R7: After an abort, sof_o and dat_vld_o stay low until the qualifier falls and rises again, even if a valid preamble and delimiter follow.
- R8: If the qualifier falls before a delimiter is found, abort_o is not raised, and the next rise of the qualifier starts a fresh hunt.
- R9: From the cycle after the delimiter, and for as long as the qualifier stays high, dat_vld_o is high and dat_o carries the current line input: rxd_i in MII mode, or {3'b000, ser_d_i} in serial mode. dat_vld_o first rises in the same cycle as sof_o.
- R10: sof_o and abort_o are single-cycle pulses and are never high together.
- R11: An abort caused by the last bit before the qualifier falls is still reported on the next cycle, while the detector returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock, one bit or nibble per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mii_mode_i | input | 1 | 1 selects nibble (MII) mode, 0 selects serial mode |
| crs_i | input | 1 | Carrier sense, qualifier in serial mode |
| ser_d_i | input | 1 | Serial receive bit |
| rx_dv_i | input | 1 | Receive data valid, qualifier in MII mode |
| rxd_i | input | 4 | Receive nibble, bit 0 earliest |
| sof_o | output | 1 | Frame-start pulse, aligned to the first data after the delimiter |
| dat_vld_o | output | 1 | Payload data valid |
| dat_o | output | 4 | Payload data (serial bit in bit 0) |
| abort_o | output | 1 | Preamble rejection pulse |

## Verification
Two events can land in the same cycle: the abort pulse and the return to idle. The bench provokes this by placing the rejecting second 0 on the last cycle that carrier is high. It then drops carrier on the very next cycle, and expects abort_o high in that cycle with dat_vld_o low. A new carrier rise must then still lock onto a clean preamble. A second overlap is the frame-start pulse and the first payload beat: the bench checks that sof_o and dat_vld_o rise together and that dat_o carries that cycle's input.

// File: rtl/eth_sfd_pkg.sv
package eth_sfd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_RECV = 2'd2,
    ST_LOCK = 2'd3
  } sfd_st_e;
endpackage

// File: rtl/sfd_ser_match.sv
module sfd_ser_match #(
  parameter int PRE_BITS   = 6,
  parameter int ABORT_BITS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hunt_i,
  input  logic bit_i,
  output logic hit_o,
  output logic bad_o
);
  localparam int WIN   = PRE_BITS + 2;
  localparam int CNT_W = $clog2(ABORT_BITS + 1);

  // newest bit at index 0: two 1s, then alternating bits ending in 0
  function automatic logic [WIN-1:0] sfd_pat();
    logic [WIN-1:0] p;
    for (int i = 0; i < WIN; i++) p[i] = (i < 2) ? 1'b1 : logic'(i % 2);
    return p;
  endfunction

  localparam logic [WIN-1:0] PAT = sfd_pat();

  logic [WIN-1:0] hist_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIN-1:0] win;

  assign win = {hist_q[WIN-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (!hunt_i) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else begin
      hist_q <= win;
      if (cnt_q != CNT_W'(ABORT_BITS)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = hunt_i && (win == PAT);
  assign bad_o = hunt_i && (cnt_q == CNT_W'(ABORT_BITS)) && !bit_i && !hist_q[0];
endmodule

// File: rtl/sfd_mii_match.sv
module sfd_mii_match #(
  parameter int          NIB_W   = 4,
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hunt_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             hit_o,
  output logic             bad_o
);
  logic [NIB_W-1:0] prev_q;
  logic             prev_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else begin
      prev_q     <= hunt_i ? nib_i : '0;
      prev_vld_q <= hunt_i;
    end
  end

  assign hit_o = hunt_i && prev_vld_q && (prev_q == PRE_NIB) && (nib_i == SFD_NIB);
  assign bad_o = hunt_i && !hit_o && (nib_i != PRE_NIB);
endmodule

// File: rtl/sfd_fsm.sv
module sfd_fsm
  import eth_sfd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qual_i,
  input  logic hit_i,
  input  logic bad_i,
  output logic hunt_o,
  output logic recv_o,
  output logic sof_o,
  output logic abort_o
);
  sfd_st_e st_q, st_d;
  logic sof_q, abort_q;

  assign hunt_o = qual_i && (st_q == ST_IDLE || st_q == ST_HUNT);

  always_comb begin
    st_d = st_q;
    if (!qual_i)     st_d = ST_IDLE;
    else if (hunt_o) st_d = hit_i ? ST_RECV : (bad_i ? ST_LOCK : ST_HUNT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sof_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sof_q   <= hunt_o && hit_i;
      abort_q <= hunt_o && bad_i && !hit_i;
    end
  end

  assign recv_o  = (st_q == ST_RECV) && qual_i;
  assign sof_o   = sof_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/eth_sfd_detect.sv
module eth_sfd_detect #(
  parameter int PRE_BITS   = 6,
  parameter int ABORT_BITS = 16,
  parameter int NIB_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mii_mode_i,
  input  logic             crs_i,
  input  logic             ser_d_i,
  input  logic             rx_dv_i,
  input  logic [NIB_W-1:0] rxd_i,
  output logic             sof_o,
  output logic             dat_vld_o,
  output logic [NIB_W-1:0] dat_o,
  output logic             abort_o
);
  logic qual, hunt;
  logic ser_hunt, mii_hunt;
  logic ser_hit, ser_bad, mii_hit, mii_bad;
  logic hit, bad;

  assign qual     = mii_mode_i ? rx_dv_i : crs_i;
  assign ser_hunt = hunt && !mii_mode_i;
  assign mii_hunt = hunt && mii_mode_i;

  sfd_ser_match #(.PRE_BITS(PRE_BITS), .ABORT_BITS(ABORT_BITS)) u_ser (
    .clk_i (clk_i), .rst_ni(rst_ni), .hunt_i(ser_hunt), .bit_i(ser_d_i),
    .hit_o (ser_hit), .bad_o(ser_bad)
  );

  sfd_mii_match #(.NIB_W(NIB_W)) u_mii (
    .clk_i (clk_i), .rst_ni(rst_ni), .hunt_i(mii_hunt), .nib_i(rxd_i),
    .hit_o (mii_hit), .bad_o(mii_bad)
  );

  assign hit = mii_mode_i ? mii_hit : ser_hit;
  assign bad = mii_mode_i ? mii_bad : ser_bad;

  sfd_fsm u_fsm (
    .clk_i  (clk_i), .rst_ni(rst_ni), .qual_i(qual),
    .hit_i  (hit), .bad_i(bad),
    .hunt_o (hunt), .recv_o(dat_vld_o), .sof_o(sof_o), .abort_o(abort_o)
  );

  assign dat_o = mii_mode_i ? rxd_i : {{(NIB_W-1){1'b0}}, ser_d_i};
endmodule

// File: rtl/sfd_detect_chk.sv
module sfd_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mii_mode_i,
  input logic       crs_i,
  input logic       ser_d_i,
  input logic       rx_dv_i,
  input logic [3:0] rxd_i,
  input logic       sof_o,
  input logic       dat_vld_o,
  input logic       abort_o
);
  // R10
  sof_abort_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sof_o && abort_o));
  // R10
  sof_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);
  // R10
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  // R2
  ser_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o && !$past(mii_mode_i)) |-> ($past(crs_i) && $past(ser_d_i)));
  // R5
  mii_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o && $past(mii_mode_i)) |-> ($past(rx_dv_i) && $past(rxd_i) == 4'hD));
  // R9
  vld_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dat_vld_o) |-> sof_o);
  // R7
  lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !dat_vld_o);
endmodule

bind eth_sfd_detect sfd_detect_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mii_mode_i(mii_mode_i), .crs_i(crs_i),
  .ser_d_i(ser_d_i), .rx_dv_i(rx_dv_i), .rxd_i(rxd_i), .sof_o(sof_o),
  .dat_vld_o(dat_vld_o), .abort_o(abort_o)
);

// File: tb/sim_eth_sfd_detect.sv
module sim_eth_sfd_detect;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mii_mode_i = 1'b0, crs_i = 1'b0, ser_d_i = 1'b0, rx_dv_i = 1'b0;
  logic [3:0] rxd_i = 4'h0;
  logic sof_o, dat_vld_o, abort_o;
  logic [3:0] dat_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  eth_sfd_detect u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mii_mode_i(mii_mode_i), .crs_i(crs_i),
    .ser_d_i(ser_d_i), .rx_dv_i(rx_dv_i), .rxd_i(rxd_i), .sof_o(sof_o),
    .dat_vld_o(dat_vld_o), .dat_o(dat_o), .abort_o(abort_o)
  );

  // {req, mode, qual, data, exp sof, exp abort, exp vld}; expectations seen while row is applied
  localparam int NV = 23;
  localparam logic [12:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 4'h0, 3'b000},
    {4'd2, 1'b0, 1'b1, 4'h1, 3'b000},
    {4'd2, 1'b0, 1'b1, 4'h0, 3'b000},
    {4'd2, 1'b0, 1'b1, 4'h1, 3'b000},
    {4'd2, 1'b0, 1'b1, 4'h0, 3'b000},
    {4'd2, 1'b0, 1'b1, 4'h1, 3'b000},
    {4'd2, 1'b0, 1'b1, 4'h0, 3'b000},
    {4'd2, 1'b0, 1'b1, 4'h1, 3'b000},
    {4'd2, 1'b0, 1'b1, 4'h1, 3'b000},
    {4'd2, 1'b0, 1'b1, 4'h0, 3'b101},
    {4'd9, 1'b0, 1'b1, 4'h1, 3'b001},
    {4'd9, 1'b0, 1'b0, 4'h0, 3'b000},
    {4'd8, 1'b0, 1'b0, 4'h0, 3'b000},
    {4'd5, 1'b1, 1'b1, 4'h5, 3'b000},
    {4'd5, 1'b1, 1'b1, 4'h5, 3'b000},
    {4'd5, 1'b1, 1'b1, 4'hD, 3'b000},
    {4'd5, 1'b1, 1'b1, 4'h3, 3'b101},
    {4'd9, 1'b1, 1'b0, 4'h0, 3'b000},
    {4'd6, 1'b1, 1'b1, 4'hA, 3'b000},
    {4'd6, 1'b1, 1'b1, 4'h5, 3'b010},
    {4'd7, 1'b1, 1'b1, 4'hD, 3'b000},
    {4'd7, 1'b1, 1'b1, 4'h3, 3'b000},
    {4'd7, 1'b1, 1'b0, 4'h0, 3'b000}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic q, input logic [3:0] d);
    @(negedge clk);
    mii_mode_i = m;
    crs_i      = m ? 1'b0 : q;
    rx_dv_i    = m ? q : 1'b0;
    ser_d_i    = d[0];
    rxd_i      = m ? d : 4'h0;
    #1;
  endtask

  task automatic ser_pre();
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, {3'b0, (i >= 6) ? 1'b1 : logic'(i % 2 == 0)});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: outputs quiet in reset despite live line
    step(1'b0, 1'b1, 4'h1);
    step(1'b0, 1'b1, 4'h1);
    chk("R1", {1'b0, sof_o, abort_o, dat_vld_o}, 4'h0);
    step(1'b0, 1'b0, 4'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][8], VEC[v][7], VEC[v][6:3]);
      n_chk++;
      if ({sof_o, abort_o, dat_vld_o} !== VEC[v][2:0]) begin
        n_fail++;
        $display("FAIL R%0d row %0d: actual %b expected %b", VEC[v][12:9], v,
                 {sof_o, abort_o, dat_vld_o}, VEC[v][2:0]);
      end
    end
    step(1'b0, 1'b0, 4'h0);

    // R3: only four alternating bits before 11
    step(1'b0, 1'b1, 4'h1); step(1'b0, 1'b1, 4'h0);
    step(1'b0, 1'b1, 4'h1); step(1'b0, 1'b1, 4'h0);
    step(1'b0, 1'b1, 4'h1); step(1'b0, 1'b1, 4'h1);
    step(1'b0, 1'b1, 4'h0);
    chk("R3", {2'b0, sof_o, dat_vld_o}, 4'h0);

    // R8: carrier drop mid-preamble, no abort, fresh hunt afterwards
    step(1'b0, 1'b0, 4'h0);
    chk("R8", {3'b0, abort_o}, 4'h0);
    step(1'b0, 1'b0, 4'h0);
    chk("R8", {3'b0, abort_o}, 4'h0);
    ser_pre();
    step(1'b0, 1'b1, 4'h1);
    // R9: sof and first payload beat together, serial bit on dat_o[0]
    chk("R9", {sof_o, dat_vld_o, 2'b0}, 4'hC);
    chk("R9", dat_o, 4'h1);
    step(1'b0, 1'b1, 4'h0);
    chk("R9", dat_o, 4'h0);
    chk("R10", {2'b0, sof_o, abort_o}, 4'h0);
    step(1'b0, 1'b0, 4'h0);

    // R4: 16 zeros (idx 0..15) give no abort; idx 16 zero does
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 4'h0);
    step(1'b0, 1'b1, 4'h0);
    chk("R4", {3'b0, abort_o}, 4'h0);
    step(1'b0, 1'b1, 4'h1);
    chk("R4", {3'b0, abort_o}, 4'h1);
    step(1'b0, 1'b1, 4'h0);
    chk("R10", {3'b0, abort_o}, 4'h0);
    // R7: valid preamble while locked is ignored
    ser_pre();
    step(1'b0, 1'b1, 4'h1);
    chk("R7", {2'b0, sof_o, dat_vld_o}, 4'h0);
    step(1'b0, 1'b0, 4'h0);
    ser_pre();
    step(1'b0, 1'b1, 4'h1);
    chk("R7", {2'b0, sof_o, dat_vld_o}, 4'h3);
    step(1'b0, 1'b0, 4'h0);

    // R11: rejecting zero on last carrier cycle
    for (int i = 0; i < 17; i++) step(1'b0, 1'b1, 4'h0);
    step(1'b0, 1'b0, 4'h0);
    chk("R11", {2'b0, abort_o, dat_vld_o}, 4'h2);
    step(1'b0, 1'b0, 4'h0);
    chk("R11", {3'b0, abort_o}, 4'h0);
    ser_pre();
    step(1'b0, 1'b1, 4'h0);
    chk("R11", {3'b0, sof_o}, 4'h1);
    step(1'b0, 1'b0, 4'h0);

    // R6: D as first nibble
    step(1'b1, 1'b1, 4'hD);
    step(1'b1, 1'b1, 4'h5);
    chk("R6", {3'b0, abort_o}, 4'h1);
    step(1'b1, 1'b0, 4'h0);
    // R8: MII drop after preamble only
    step(1'b1, 1'b1, 4'h5);
    step(1'b1, 1'b1, 4'h5);
    step(1'b1, 1'b0, 4'h0);
    chk("R8", {3'b0, abort_o}, 4'h0);
    // R5 / R9: minimal delimiter byte then payload on dat_o
    step(1'b1, 1'b1, 4'h5);
    step(1'b1, 1'b1, 4'hD);
    step(1'b1, 1'b1, 4'hA);
    chk("R5", {2'b0, sof_o, dat_vld_o}, 4'h3);
    chk("R9", dat_o, 4'hA);
    step(1'b1, 1'b1, 4'h6);
    chk("R9", dat_o, 4'h6);
    step(1'b1, 1'b0, 4'h0);
    chk("R9", {3'b0, dat_vld_o}, 4'h0);

    finish_run();
  end
endmodule